// File: doc/BRIEF.md
# Output-Stage Mute and Soft-Start Sequencer

This block controls when the power bridges of a two-channel switching amplifier may switch. It watches an active-low power-down pin, an active-low mute pin and a mute request from the on-chip protection logic. Its outputs are a bridge enable, a soft-start override with its own pulse stream, and a flag that marks normal operation. It runs on the modulator clock, which is 256 times the audio sample rate.

When power-down is released, the block waits a fixed hold time before it honours an un-mute. This applies even if the mute pin was released first, so power-down release always comes before un-mute. On any un-mute it takes over the bridge drive. It emits a pulse pattern whose duty climbs in equal steps from zero to one half over a set number of PWM frames. This walks the filtered bridge output from 0 V up to mid-scale. Only then does it hand the bridge to the modulator.

A mute, a protection mute request or a qualified power-down opens the bridges at once, including in the middle of a ramp. Low pulses on the power-down pin shorter than about 500 ns are filtered out.

Top module: `amp_mute_seq`

## Requirements
- R1: While `por_n` is low, and whenever power-down has been recognised, `bridge_en`, `ss_override`, `ss_pwm` and `active` are all 0.
- R2: A low level on `pdn_n` is recognised only after it has lasted MIN_LOW_CYC clocks, where MIN_LOW_CYC is 500 ns rounded up to whole clock periods (50 at a 10 ns clock). A shorter low pulse leaves `active` at 1.
- R3: After `pdn_n` rises, `bridge_en` stays 0 for at least HOLD_CYC clocks, even if `mute_n` was already high. It then rises within 8 clocks after that hold time.
- R4: During the soft start, PWM frame k (k = 0 to RAMP_FRAMES) is FRAME_LEN clocks long. Exactly k*STEP clocks of that frame have `ss_pwm` = 1, where STEP = (FRAME_LEN/2)/RAMP_FRAMES. So the duty goes from 0 up to 50 %.
- R5: `ss_override` is 1 for exactly (RAMP_FRAMES+1)*FRAME_LEN clocks from the rise of `bridge_en`. In the next clock `active` = 1, `ss_override` = 0 and `bridge_en` stays 1.
- R6: Releasing `mute_n` after a mute starts a new soft start from zero duty. `bridge_en` rises within 4 clocks of the release.
- R7: A low `mute_n` forces `bridge_en` to 0 in the second clock after the pin falls. This holds during the ramp and during normal operation.
- R8: `fault_mute` = 1 forces `bridge_en` and `active` to 0 in the same cycle. When it clears, a fresh soft start follows.
- R9: A power-down recognised during the soft start forces all outputs to 0. The following release again waits at least HOLD_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock (256 x sample rate) |
| por_n | input | 1 | Power-on reset of the control logic, active low, asynchronous |
| pdn_n | input | 1 | Power-down pin, active low, asynchronous to clk |
| mute_n | input | 1 | Mute pin, active low, asynchronous to clk |
| fault_mute | input | 1 | Mute request from the protection logic, synchronous, active high |
| bridge_en | output | 1 | 1 lets the bridge switches conduct; 0 opens all of them |
| ss_override | output | 1 | 1 while the soft-start pattern drives the bridge instead of the modulator |
| ss_pwm | output | 1 | Soft-start pulse stream, 0 whenever ss_override is 0 |
| active | output | 1 | 1 when the modulator owns the bridge (normal operation) |

## Verification
Suppose the sequence state is wrong, for example stuck in the hold phase or skipping it. Then the time from power-down release to the rise of `bridge_en` moves outside its window, and this shows within a few tens of clocks. A wrong frame or phase count in the ramp changes the number of high clocks in some frame, or makes `ss_override` last longer or shorter. So the per-frame pulse counts and the hand-over cycle show the fault within one ramp. If the block failed to leave the ramp or run states on a mute, a fault request or a power-down, `bridge_en` would stay high. The bench checks this at a fixed latency of zero or two clocks.

// File: rtl/amp_mute_seq_pkg.sv
package amp_mute_seq_pkg;
   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_HOLD  = 3'd1,
      ST_MUTED = 3'd2,
      ST_RAMP  = 3'd3,
      ST_RUN   = 3'd4
   } seq_state_e;
endpackage

// File: rtl/amp_mute_sync.sv
module amp_mute_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL}};
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/amp_mute_pdn_qual.sv
module amp_mute_pdn_qual #(
   parameter int MIN_LOW_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pdn_s,
   output logic run_ok
);
   generate
      if (MIN_LOW_CYC <= 1) begin : g_direct
         logic ok_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ok_q <= 1'b0;
            else        ok_q <= pdn_s;
         end
         assign run_ok = ok_q;
      end else begin : g_counted
         localparam int CW = $clog2(MIN_LOW_CYC + 1);
         logic [CW-1:0] low_cnt_q;
         logic          ok_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               low_cnt_q <= '0;
               ok_q      <= 1'b0;
            end else if (pdn_s) begin
               low_cnt_q <= '0;
               ok_q      <= 1'b1;
            end else if (low_cnt_q == CW'(MIN_LOW_CYC - 1)) begin
               ok_q      <= 1'b0;
            end else begin
               low_cnt_q <= low_cnt_q + 1'b1;
            end
         end
         assign run_ok = ok_q;
      end
   endgenerate
endmodule

// File: rtl/amp_mute_ramp.sv
module amp_mute_ramp #(
   parameter int FRAME_LEN   = 256,
   parameter int RAMP_FRAMES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic pwm,
   output logic done
);
   localparam int PH_W = $clog2(FRAME_LEN);
   localparam int FR_W = $clog2(RAMP_FRAMES + 1);
   localparam int STEP = (FRAME_LEN / 2) / RAMP_FRAMES;

   logic [PH_W-1:0] phase_q;
   logic [FR_W-1:0] frame_q;
   logic [PH_W-1:0] duty;
   logic            frame_end;

   assign frame_end = (phase_q == PH_W'(FRAME_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         frame_q <= '0;
      end else if (!en) begin
         phase_q <= '0;
         frame_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
         if (frame_end && frame_q != FR_W'(RAMP_FRAMES))
            frame_q <= frame_q + 1'b1;
      end
   end

   always_comb duty = PH_W'(int'(frame_q) * STEP);

   assign pwm  = en && (phase_q < duty);
   assign done = en && frame_end && (frame_q == FR_W'(RAMP_FRAMES));
endmodule

// File: rtl/amp_mute_seq.sv
module amp_mute_seq
   import amp_mute_seq_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 88,
   parameter int MIN_LOW_NS    = 500,
   parameter int HOLD_CYC      = 4096,
   parameter int FRAME_LEN     = 256,
   parameter int RAMP_FRAMES   = 32,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic pdn_n,
   input  logic mute_n,
   input  logic fault_mute,
   output logic bridge_en,
   output logic ss_override,
   output logic ss_pwm,
   output logic active
);
   localparam int MIN_LOW_CYC = (MIN_LOW_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
   localparam int HOLD_W      = $clog2(HOLD_CYC + 1);

   initial begin
      if (SYNC_STAGES < 2)                       $error("SYNC_STAGES must be at least 2");
      if (HOLD_CYC < 1)                          $error("HOLD_CYC must be at least 1");
      if (RAMP_FRAMES < 1)                       $error("RAMP_FRAMES must be at least 1");
      if (FRAME_LEN < 4 || (FRAME_LEN & (FRAME_LEN - 1)) != 0)
                                                 $error("FRAME_LEN must be a power of two >= 4");
      if (((FRAME_LEN / 2) % RAMP_FRAMES) != 0)  $error("FRAME_LEN/2 must divide by RAMP_FRAMES");
      if (CLK_PERIOD_NS < 1)                     $error("CLK_PERIOD_NS must be positive");
   end

   logic pdn_s, mute_s, run_ok, muted;
   logic ramp_en, ramp_pwm, ramp_done;
   seq_state_e         state_q, state_d;
   logic [HOLD_W-1:0]  hold_q, hold_d;

   amp_mute_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pdn_sync (
      .clk(clk), .rst_n(por_n), .d(pdn_n), .q(pdn_s));

   amp_mute_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mute_sync (
      .clk(clk), .rst_n(por_n), .d(mute_n), .q(mute_s));

   amp_mute_pdn_qual #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_qual (
      .clk(clk), .rst_n(por_n), .pdn_s(pdn_s), .run_ok(run_ok));

   assign muted = !mute_s || fault_mute;

   always_comb begin
      state_d = state_q;
      hold_d  = hold_q;
      if (!run_ok) begin
         state_d = ST_OFF;
         hold_d  = '0;
      end else begin
         unique case (state_q)
            ST_OFF: begin
               state_d = ST_HOLD;
               hold_d  = '0;
            end
            ST_HOLD: begin
               if (hold_q == HOLD_W'(HOLD_CYC - 1)) state_d = ST_MUTED;
               else                                 hold_d  = hold_q + 1'b1;
            end
            ST_MUTED: if (!muted) state_d = ST_RAMP;
            ST_RAMP: begin
               if (muted)          state_d = ST_MUTED;
               else if (ramp_done) state_d = ST_RUN;
            end
            ST_RUN:  if (muted) state_d = ST_MUTED;
            default: state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= ST_OFF;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         hold_q  <= hold_d;
      end
   end

   assign ramp_en = (state_q == ST_RAMP) && !muted && run_ok;

   amp_mute_ramp #(.FRAME_LEN(FRAME_LEN), .RAMP_FRAMES(RAMP_FRAMES)) u_ramp (
      .clk(clk), .rst_n(por_n), .en(ramp_en), .pwm(ramp_pwm), .done(ramp_done));

   assign bridge_en   = (state_q == ST_RAMP || state_q == ST_RUN) && !muted && run_ok;
   assign ss_override = ramp_en;
   assign ss_pwm      = ramp_pwm;
   assign active      = (state_q == ST_RUN) && !muted && run_ok;
endmodule

// File: rtl/amp_mute_seq_chk.sv
module amp_mute_seq_chk (
   input logic clk,
   input logic por_n,
   input logic mute_n,
   input logic fault_mute,
   input logic bridge_en,
   input logic ss_override,
   input logic ss_pwm,
   input logic active
);
   // R4: pulses only appear while the soft-start pattern owns the bridge
   p_pwm_in_override_r4: assert property (@(posedge clk) disable iff (!por_n)
      ss_pwm |-> ss_override);

   // R5: the override never runs with the bridge open
   p_override_bridge_r5: assert property (@(posedge clk) disable iff (!por_n)
      ss_override |-> bridge_en);

   // R5: normal operation excludes the override and needs the bridge
   p_active_excl_r5: assert property (@(posedge clk) disable iff (!por_n)
      active |-> (bridge_en && !ss_override));

   // R5: normal operation is only entered straight from a soft start
   p_run_entry_r5: assert property (@(posedge clk) disable iff (!por_n)
      $rose(active) |-> $past(ss_override));

   // R8: a protection mute request opens the bridge in the same cycle
   p_fault_opens_r8: assert property (@(posedge clk) disable iff (!por_n)
      fault_mute |-> (!bridge_en && !active));

   // R7: mute low for three sampled cycles leaves the bridge open
   p_mute_opens_r7: assert property (@(posedge clk) disable iff (!por_n)
      (!mute_n && $past(!mute_n, 1) && $past(!mute_n, 2)) |-> !bridge_en);
endmodule

bind amp_mute_seq amp_mute_seq_chk u_chk (
   .clk(clk), .por_n(por_n), .mute_n(mute_n), .fault_mute(fault_mute),
   .bridge_en(bridge_en), .ss_override(ss_override), .ss_pwm(ss_pwm),
   .active(active));

// File: tb/amp_mute_seq_tb.sv
`timescale 1ns/1ps
module amp_mute_seq_tb;
   localparam int CLK_NS  = 10;
   localparam int HOLD    = 20;
   localparam int FL      = 16;
   localparam int RF      = 4;
   localparam int STEP    = (FL / 2) / RF;
   localparam int MIN_LOW = (500 + CLK_NS - 1) / CLK_NS;

   logic clk = 1'b0;
   logic por_n, pdn_n, mute_n, fault_mute;
   logic bridge_en, ss_override, ss_pwm, active;
   int   n_chk = 0;
   int   n_fail = 0;

   always #(CLK_NS / 2) clk = ~clk;

   amp_mute_seq #(
      .CLK_PERIOD_NS(CLK_NS), .MIN_LOW_NS(500), .HOLD_CYC(HOLD),
      .FRAME_LEN(FL), .RAMP_FRAMES(RF), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .por_n(por_n), .pdn_n(pdn_n), .mute_n(mute_n),
      .fault_mute(fault_mute), .bridge_en(bridge_en),
      .ss_override(ss_override), .ss_pwm(ss_pwm), .active(active));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic all_off(input string req);
      chk(!bridge_en && !ss_override && !ss_pwm && !active, req,
          {bridge_en, ss_override, ss_pwm, active}, 0);
   endtask

   task automatic wait_bridge(output int n);
      n = 0;
      while (!bridge_en && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   // R4 / R5: per-frame high counts, override length, hand-over
   task automatic measure_ramp(input string req);
      int ovr_miss = 0;
      for (int k = 0; k <= RF; k++) begin
         int hi = 0;
         for (int i = 0; i < FL; i++) begin
            if (ss_pwm) hi++;
            if (!ss_override || !bridge_en) ovr_miss++;
            @(negedge clk);
         end
         chk(hi == k * STEP, {req, " R4 frame duty"}, hi, k * STEP);
      end
      chk(ovr_miss == 0, {req, " R5 override length"}, ovr_miss, 0);
      chk(active && !ss_override && bridge_en, {req, " R5 hand-over"},
          {active, ss_override, bridge_en}, 3'b101);
   endtask

   task automatic t_reset_state();
      por_n = 0; pdn_n = 0; mute_n = 0; fault_mute = 0;
      repeat (4) @(negedge clk);
      all_off("R1 during por");
      por_n = 1;
      repeat (10) @(negedge clk);
      all_off("R1 powered down");
   endtask

   task automatic t_power_up();
      int n;
      mute_n = 1;
      repeat (5) @(negedge clk);
      all_off("R3 mute released before pdn");
      pdn_n = 1;
      wait_bridge(n);
      chk(n >= HOLD && n <= HOLD + 8, "R3 hold before un-mute", n, HOLD + 5);
      measure_ramp("power-up");
   endtask

   task automatic t_glitch();
      int drop = 0;
      pdn_n = 0;
      for (int i = 0; i < MIN_LOW - 6; i++) begin
         if (!active) drop++;
         @(negedge clk);
      end
      pdn_n = 1;
      repeat (6) begin
         if (!active) drop++;
         @(negedge clk);
      end
      chk(drop == 0, "R2 short pdn pulse ignored", drop, 0);
      pdn_n = 0;
      repeat (MIN_LOW + 6) @(negedge clk);
      all_off("R2 long pdn pulse recognised");
   endtask

   task automatic t_repower();
      int n;
      pdn_n = 1;
      wait_bridge(n);
      chk(n >= HOLD && n <= HOLD + 8, "R3 hold after second release", n, HOLD + 5);
      measure_ramp("re-power");
   endtask

   task automatic t_mute();
      int n;
      mute_n = 0;
      @(negedge clk);
      chk(bridge_en, "R7 bridge still on one clock after mute", bridge_en, 1);
      @(negedge clk);
      chk(!bridge_en && !active, "R7 bridge open two clocks after mute", bridge_en, 0);
      repeat (10) @(negedge clk);
      mute_n = 1;
      wait_bridge(n);
      chk(n <= 4, "R6 un-mute latency", n, 3);
      measure_ramp("R6 un-mute");
   endtask

   task automatic t_fault();
      int n;
      fault_mute = 1;
      #1;
      chk(!bridge_en && !active, "R8 fault opens bridge same cycle", bridge_en, 0);
      repeat (5) @(negedge clk);
      all_off("R8 fault held");
      fault_mute = 0;
      wait_bridge(n);
      chk(n <= 4, "R8 restart after fault", n, 1);
      measure_ramp("R8 after fault");
   endtask

   task automatic t_abort();
      int n;
      mute_n = 0;
      repeat (4) @(negedge clk);
      mute_n = 1;
      wait_bridge(n);
      repeat (FL + 5) @(negedge clk);
      chk(ss_override, "R7 ramp in progress", ss_override, 1);
      mute_n = 0;
      repeat (2) @(negedge clk);
      all_off("R7 mute aborts ramp");
      mute_n = 1;
      wait_bridge(n);
      measure_ramp("R6 ramp restarts from zero");
      mute_n = 0;
      repeat (4) @(negedge clk);
      mute_n = 1;
      wait_bridge(n);
      repeat (FL + 3) @(negedge clk);
      pdn_n = 0;
      repeat (MIN_LOW + 6) @(negedge clk);
      all_off("R9 pdn during ramp");
      pdn_n = 1;
      wait_bridge(n);
      chk(n >= HOLD && n <= HOLD + 8, "R9 hold after pdn in ramp", n, HOLD + 5);
      measure_ramp("R9 after pdn");
   endtask

   initial begin
      @(negedge clk);
      t_reset_state();
      t_power_up();
      t_glitch();
      t_repower();
      t_mute();
      t_fault();
      t_abort();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule